// File: doc/BRIEF.md
# I2C Stall Watchdog

This block sits next to an I2C controller and flags a transfer that has stopped making progress. A 32-bit configuration word holds a 3-bit divider select and a 16-bit start value. A free-running divider turns the bus clock into a slower tick, and a 16-bit down-counter loses one count on each tick. The controller reports its progress as single-cycle event strobes. Progress events (status flags, START conditions) reload the counter from the start value. End-of-transfer and fault events (STOP, arbitration loss, bus error, or slave mode while not addressed) freeze it.

When the counter runs down to zero, the block sets a sticky timeout flag, raises a one-cycle interrupt request and stops counting until the next reload. Software clears the flag by writing a one to a dedicated clear input. A start value of zero turns expiry off.

Top module: `i2c_stall_watchdog`

## Requirements
- R1: After reset the configuration reads 0x0000_0000 and both `toFlag` and `toIrq` are low.
- R2: A write with `cfgWrEn` stores bits [18:16] as the divider select and bits [15:0] as the start value. Every other bit of `cfgRdData` reads zero.
- R3: The tick comes once every 2^select clocks. A configuration write restarts the divider, so the first tick after a write falls 2^select clocks after the write edge.
- R4: A high on any bit of `statusSet` reloads the counter from the start value and starts it running.
- R5: `mstStart` (START sent) or `slvStart` (START detected) reloads the counter and starts it running.
- R6: A running counter drops by one on each tick. On the tick that takes it from 1 to 0, `toFlag` sets and the counter halts. For a reload one clock after the write, the flag appears N clocks after the reload edge when select is 0, and N·2^select − 1 clocks after it otherwise.
- R7: `toIrq` is high for exactly one clock, on the same edge that sets `toFlag`.
- R8: `mstStop`, `slvStop`, `arbLost` or `busErr` halts the counter, and no timeout follows until a new reload.
- R9: `slvMode` high while `slvAddressed` is low halts the counter in the same way.
- R10: If a halt event and a reload event occur in the same clock, the halt wins.
- R11: With a start value of 0, a reload never leads to a timeout.
- R12: `toFlag` stays set until a clock with `toClear` high clears it. An expiry in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read value |
| statusSet | input | 6 | Status-flag assertion strobes (buffer full, data empty, data not empty, NACK, general call, address match) |
| mstStart | input | 1 | Master issued START |
| slvStart | input | 1 | Slave detected START |
| mstStop | input | 1 | Master issued STOP |
| slvStop | input | 1 | Slave detected STOP |
| slvMode | input | 1 | Controller operating as slave |
| slvAddressed | input | 1 | Slave has been addressed |
| arbLost | input | 1 | Arbitration-lost strobe |
| busErr | input | 1 | Bus-error strobe |
| toClear | input | 1 | Write-one-to-clear for the timeout flag |
| toFlag | output | 1 | Sticky timeout flag |
| toIrq | output | 1 | One-clock timeout interrupt pulse |

## Verification
The reload edge is the reference point. The timeout flag and the interrupt both change on the edge that applies the last tick. That edge comes N clocks after the reload at select 0 and N·2^select − 1 clocks after it otherwise, because the write one clock earlier restarted the divider. The bench drives inputs on falling edges and counts whole clocks from the reload edge until the flag is seen. It compares that count exactly, then checks on the next falling edge that the interrupt has dropped while the flag stays set. Register reads are sampled on the falling edge after the write. Halt cases wait well past the point where a timeout would have fallen and confirm the flag is still low.

// File: rtl/i2c_wdog_pkg.sv
package i2c_wdog_pkg;
  localparam int STATUS_N = 6;

  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import i2c_wdog_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int PSC_W  = 3,
  parameter int TOUT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [REG_W-1:0]  cfgWrData,
  output logic [REG_W-1:0]  cfgRdData,
  input  cntStrobe_t        strobe,
  output logic              tick,
  output logic              cntIsOne,
  output logic              toutZero
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [PSC_W-1:0]  pscSel;
  logic [TOUT_W-1:0] toutVal;
  logic [TOUT_W-1:0] cnt;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W:0]    divSpan;
  logic [DIV_W-1:0]  divMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscSel  <= '0;
      toutVal <= '0;
    end else if (cfgWrEn) begin
      pscSel  <= cfgWrData[TOUT_W +: PSC_W];
      toutVal <= cfgWrData[TOUT_W-1:0];
    end
  end

  always_comb begin
    cfgRdData = '0;
    cfgRdData[TOUT_W-1:0]        = toutVal;
    cfgRdData[TOUT_W +: PSC_W]   = pscSel;
  end

  // Divider: free-running, phase restarted by a configuration write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (cfgWrEn) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  assign divSpan = (DIV_W+1)'(1) << pscSel;
  assign divMask = divSpan[DIV_W-1:0] - 1'b1;
  assign tick    = (divCnt & divMask) == divMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strobe.load) cnt <= toutVal;
    else if (strobe.dec)  cnt <= cnt - 1'b1;
  end

  assign cntIsOne = (cnt == TOUT_W'(1));
  assign toutZero = (toutVal == '0);

  a_r6_count_down: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec && !strobe.load |=> cnt == $past(cnt) - 1'b1);
  a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dec && !strobe.load |=> $stable(cnt));
  a_r3_write_restarts_divider: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && cfgWrData[TOUT_W +: PSC_W] != '0 |=> !tick);
endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import i2c_wdog_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_N-1:0] statusSet,
  input  logic                mstStart,
  input  logic                slvStart,
  input  logic                mstStop,
  input  logic                slvStop,
  input  logic                slvMode,
  input  logic                slvAddressed,
  input  logic                arbLost,
  input  logic                busErr,
  input  logic                toClear,
  input  logic                tick,
  input  logic                cntIsOne,
  input  logic                toutZero,
  output cntStrobe_t          strobe,
  output logic                toFlag,
  output logic                toIrq
);
  logic running;
  logic haltEvt;
  logic reloadEvt;
  logic expire;

  assign haltEvt   = mstStop | slvStop | arbLost | busErr | (slvMode & ~slvAddressed);
  assign reloadEvt = (|statusSet) | mstStart | slvStart;

  always_comb begin
    strobe.load = reloadEvt & ~haltEvt;
    strobe.dec  = running & tick & ~reloadEvt & ~haltEvt;
  end
  assign expire = strobe.dec & cntIsOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      toFlag  <= 1'b0;
      toIrq   <= 1'b0;
    end else begin
      if (haltEvt)        running <= 1'b0;
      else if (reloadEvt) running <= ~toutZero;
      else if (expire)    running <= 1'b0;
      if (expire)         toFlag  <= 1'b1;
      else if (toClear)   toFlag  <= 1'b0;
      toIrq <= expire;
    end
  end

  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    toFlag && !toClear |=> toFlag);
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    toIrq |=> !toIrq);
  a_r7_irq_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    toIrq |-> toFlag);
  a_r10_halt_wins: assert property (@(posedge clk) disable iff (!rstN)
    haltEvt |=> !running && !toIrq);
  a_r11_zero_disables: assert property (@(posedge clk) disable iff (!rstN)
    reloadEvt && !haltEvt && toutZero |=> !running);
endmodule

// File: rtl/i2c_stall_watchdog.sv
module i2c_stall_watchdog
  import i2c_wdog_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int PSC_W  = 3,
  parameter int TOUT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [REG_W-1:0]    cfgWrData,
  output logic [REG_W-1:0]    cfgRdData,
  input  logic [STATUS_N-1:0] statusSet,
  input  logic                mstStart,
  input  logic                slvStart,
  input  logic                mstStop,
  input  logic                slvStop,
  input  logic                slvMode,
  input  logic                slvAddressed,
  input  logic                arbLost,
  input  logic                busErr,
  input  logic                toClear,
  output logic                toFlag,
  output logic                toIrq
);
  cntStrobe_t strobe;
  logic tick;
  logic cntIsOne;
  logic toutZero;

  wdog_datapath #(.REG_W(REG_W), .PSC_W(PSC_W), .TOUT_W(TOUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .strobe(strobe), .tick(tick),
    .cntIsOne(cntIsOne), .toutZero(toutZero)
  );

  wdog_control u_ctl (
    .clk(clk), .rstN(rstN), .statusSet(statusSet), .mstStart(mstStart),
    .slvStart(slvStart), .mstStop(mstStop), .slvStop(slvStop),
    .slvMode(slvMode), .slvAddressed(slvAddressed), .arbLost(arbLost),
    .busErr(busErr), .toClear(toClear), .tick(tick), .cntIsOne(cntIsOne),
    .toutZero(toutZero), .strobe(strobe), .toFlag(toFlag), .toIrq(toIrq)
  );
endmodule

// File: tb/i2c_stall_watchdog_tb.sv
module i2c_stall_watchdog_tb;
  localparam real CLK_NS = 8.0;   // 125 MHz
  localparam int  NVEC   = 8;
  // {psc, tout, expected clocks from reload edge to flag}
  localparam logic [34:0] VEC [NVEC] = '{
    {3'd0, 16'd1,   16'd1},
    {3'd0, 16'd5,   16'd5},
    {3'd1, 16'd3,   16'd5},
    {3'd3, 16'd4,   16'd31},
    {3'd7, 16'd2,   16'd255},
    {3'd2, 16'd10,  16'd39},
    {3'd0, 16'd300, 16'd300},
    {3'd5, 16'd7,   16'd223}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [5:0] statusSet = '0;
  logic mstStart = 0, slvStart = 0, mstStop = 0, slvStop = 0;
  logic slvMode = 0, slvAddressed = 0, arbLost = 0, busErr = 0, toClear = 0;
  logic toFlag, toIrq;
  int checks = 0;
  int fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  i2c_stall_watchdog u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .statusSet(statusSet), .mstStart(mstStart),
    .slvStart(slvStart), .mstStop(mstStop), .slvStop(slvStop),
    .slvMode(slvMode), .slvAddressed(slvAddressed), .arbLost(arbLost),
    .busErr(busErr), .toClear(toClear), .toFlag(toFlag), .toIrq(toIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [2:0] p, input logic [15:0] t);
    cfgWrEn = 1; cfgWrData = {13'd0, p, t};
    step();
    cfgWrEn = 0; cfgWrData = '0;
  endtask

  task automatic clearAll();
    statusSet = '0; mstStart = 0; slvStart = 0; mstStop = 0; slvStop = 0;
    slvMode = 0; slvAddressed = 0; arbLost = 0; busErr = 0; toClear = 0;
  endtask

  // counts clocks until the flag rises, up to lim
  task automatic waitFlag(input int lim, output int k);
    k = 0;
    while (!toFlag && k < lim) begin
      step();
      k++;
    end
  endtask

  task automatic clearFlag();
    toClear = 1; step(); toClear = 0;
  endtask

  // run with tout 4, apply a halt kind one clock into the count, expect no timeout
  task automatic haltCase(input int kind, input string req);
    int k;
    writeCfg(3'd0, 16'd4);
    mstStart = 1; step(); clearAll();
    step();
    case (kind)
      0: mstStop = 1;
      1: slvStop = 1;
      2: arbLost = 1;
      3: busErr = 1;
      default: begin slvMode = 1; slvAddressed = 0; end
    endcase
    step(); clearAll();
    waitFlag(20, k);
    check(req, {31'd0, toFlag}, 32'd0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int k;
    @(negedge clk);
    check("R1 reset cfg", cfgRdData, 32'd0);
    check("R1 reset flag", {30'd0, toFlag, toIrq}, 32'd0);
    step(); rstN = 1; step();

    // vector table: write, reload one clock later, measure expiry time
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] p; logic [15:0] t; logic [15:0] e;
      {p, t, e} = VEC[i];
      writeCfg(p, t);
      check("R2 readback", cfgRdData, {13'd0, p, t});
      if (i % 2 == 0) mstStart = 1; else slvStart = 1;   // R5
      step(); clearAll();
      waitFlag(400, k);
      check("R3 R6 expiry clocks", k, {16'd0, e});
      check("R7 irq with flag", {31'd0, toIrq}, 32'd1);
      step();
      check("R7 irq single clock", {31'd0, toIrq}, 32'd0);
      check("R12 flag sticky", {31'd0, toFlag}, 32'd1);
      clearFlag();
      check("R12 cleared", {31'd0, toFlag}, 32'd0);
    end

    // R2 reserved bits
    cfgWrEn = 1; cfgWrData = 32'hFFFF_FFFF; step(); cfgWrEn = 0;
    check("R2 reserved zero", cfgRdData, 32'h0007_FFFF);

    // R4 each status bit restarts the count
    for (int b = 0; b < 6; b++) begin
      writeCfg(3'd0, 16'd5);
      mstStart = 1; step(); clearAll();
      step(); step(); step();
      check("R4 no early flag", {31'd0, toFlag}, 32'd0);
      statusSet[b] = 1'b1; step(); clearAll();
      waitFlag(40, k);
      check("R4 status reload", k, 32'd5);
      clearFlag();
    end

    // R5 slave START reload also restarts a running count
    writeCfg(3'd0, 16'd6);
    mstStart = 1; step(); clearAll();
    step(); step();
    slvStart = 1; step(); clearAll();
    waitFlag(40, k);
    check("R5 start restart", k, 32'd6);
    clearFlag();

    haltCase(0, "R8 master stop");
    haltCase(1, "R8 slave stop");
    haltCase(2, "R8 arbitration lost");
    haltCase(3, "R8 bus error");
    haltCase(4, "R9 not addressed");

    // R8 a halted counter resumes after a new reload
    writeCfg(3'd0, 16'd3);
    mstStart = 1; step(); clearAll();
    waitFlag(40, k);
    check("R8 reload after halt", k, 32'd3);
    clearFlag();

    // R9 addressed slave keeps counting
    writeCfg(3'd0, 16'd4);
    slvMode = 1; slvAddressed = 1; slvStart = 1; step(); slvStart = 0;
    waitFlag(40, k);
    check("R9 addressed slave counts", k, 32'd4);
    clearAll(); clearFlag();

    // R10 halt and reload in the same clock while running
    writeCfg(3'd0, 16'd4);
    mstStart = 1; step(); clearAll();
    step();
    mstStart = 1; mstStop = 1; step(); clearAll();
    waitFlag(20, k);
    check("R10 halt wins", {31'd0, toFlag}, 32'd0);

    // R11 zero start value
    writeCfg(3'd0, 16'd0);
    mstStart = 1; step(); clearAll();
    waitFlag(50, k);
    check("R11 zero disables", {31'd0, toFlag}, 32'd0);
    check("R11 no irq", {31'd0, toIrq}, 32'd0);

    // R12 expiry wins over a clear in the same clock
    writeCfg(3'd0, 16'd2);
    mstStart = 1; step(); clearAll();
    step();
    toClear = 1; step(); toClear = 0;
    check("R12 set beats clear", {31'd0, toFlag}, 32'd1);
    clearFlag();
    check("R12 clear after", {31'd0, toFlag}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule